// File: doc/BRIEF.md
# Pipeline hazard control unit

This unit makes the per-cycle control decisions for an in-order pipeline with five steps: fetch, decode with operand read, execute, data access and write-back. The decoder gives it the fields of the instruction now in decode: source and destination register numbers, whether each source is used, whether a register is written, and load, store and branch flags. The unit carries these fields down its own stage registers. From them it chooses the bypass source for both execute operands. It also decides whether to freeze fetch and decode, whether to discard the two instructions fetched behind a taken branch, and whether fetch must give way to a data access on a shared memory port. The datapath, register file, ALU and memories sit outside the unit.

Each cycle the unit settles on one action, in a fixed priority order. ACT_SQUASH is chosen when a branch in execute is taken. ACT_DATA_STALL is chosen when the decode instruction depends on a result it cannot receive in time. ACT_PORT_HOLD is chosen when a load or store in the data stage owns the single memory port. ACT_ADVANCE is chosen otherwise. The stage registers update from the action picked for that cycle. ACT_ADVANCE and ACT_PORT_HOLD move decode into execute and either load a new fetch or load a bubble into decode. ACT_DATA_STALL keeps decode and sends a bubble to execute. ACT_SQUASH empties both decode and execute. Two mode pins choose whether bypassing is used and whether the memory port is shared. A free-running cycle counter lets a program's run length be measured.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: With bypassing on, an execute operand that is used and whose register equals the destination of a valid, register-writing instruction in the data stage selects code 01 on `fwd_a`/`fwd_b`.
- R2: Failing R1, a match against a valid, writing instruction in write-back selects code 10. Code 00 means the register file. A match in both stages gives 01. Register 0 is matched like any other register.
- R3: A valid load in execute whose destination is read by the instruction in decode raises `stall` and drops `fetch_go` for exactly one cycle. Decode is kept, execute gets a bubble, and the consumer then reaches execute with code 10 for that operand.
- R4: With bypassing off, `fwd_a` and `fwd_b` stay 00. `stall` is raised whenever the decode instruction reads the destination of a writing instruction in execute or in the data stage.
- R5: With `mem_shared` high, `fetch_go` is 0 in every cycle in which a valid load or store occupies the data stage. Decode then receives a bubble.
- R6: A valid branch in execute is taken when `z_flag` differs from its `id_br_ne` bit (0 = taken on Z set, 1 = taken on Z clear). In that cycle `flush` is 1, and in the next cycle decode and execute are both empty.
- R7: A branch whose condition is false raises no `flush`, and the two instructions behind it carry on.
- R8: `flush` overrides a data stall or a port conflict in the same cycle: `stall` reads 0 and the squash still takes place.
- R9: `stage_valid` = {write-back, data, execute, decode} valid. Squashed slots and bubbles are invalid and never produce a bypass match.
- R10: `cycle_count` is 0 after reset and rises by one on every clock. Seven instructions with two load-use stalls have their last write-back in the 13th cycle. The same work reordered takes 11 cycles.
- R11: During reset all valid bits, `cycle_count`, `stall`, `flush` and both bypass selects are 0.
- R12: With no hazard, `fetch_go` equals `fetch_avail`, and every valid instruction moves one stage per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1 = bypass paths in use |
| mem_shared | input | 1 | 1 = instruction and data share one memory port |
| fetch_avail | input | 1 | An instruction is available to fetch this cycle |
| z_flag | input | 1 | Zero flag seen by a branch in execute |
| id_dst | input | REG_W | Destination register of the decode instruction |
| id_src_a | input | REG_W | First source register of the decode instruction |
| id_src_b | input | REG_W | Second source register of the decode instruction |
| id_wr | input | 1 | Decode instruction writes a register |
| id_use_a | input | 1 | First source is read |
| id_use_b | input | 1 | Second source is read |
| id_load | input | 1 | Decode instruction is a load |
| id_store | input | 1 | Decode instruction is a store |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_ne | input | 1 | Branch condition: 0 taken on Z set, 1 taken on Z clear |
| fetch_go | output | 1 | Fetch proceeds this cycle |
| stall | output | 1 | Freeze fetch and decode, bubble into execute |
| flush | output | 1 | Discard the instructions in fetch and decode |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 data stage, 10 write-back |
| fwd_b | output | 2 | Operand B source, same encoding |
| stage_valid | output | 4 | {write-back, data, execute, decode} valid bits |
| cycle_count | output | CNT_W | Cycles since reset |

## Verification
If the unit's copy of the pipeline drifts from the real instruction flow, the fault shows up at the ports within the cycle it happens or one cycle later. A missing or extra bubble shifts `stage_valid` at once. A stale destination in a stage register gives the wrong `fwd_a`/`fwd_b` code on the next dependent operand. A dropped squash lets a discarded instruction show as valid in execute on the next clock. Because the bench's model predicts every output on every cycle, a one-cycle timing error in a stall or flush is caught on the cycle it occurs.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_sel_e;

    typedef enum logic [1:0] {
        ACT_ADVANCE    = 2'd0,
        ACT_PORT_HOLD  = 2'd1,
        ACT_DATA_STALL = 2'd2,
        ACT_SQUASH     = 2'd3
    } act_e;

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             en,
    input  logic             use_src,
    input  logic [REG_W-1:0] src,
    input  logic             mem_v,
    input  logic             mem_wr,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             wb_v,
    input  logic             wb_wr,
    input  logic [REG_W-1:0] wb_dst,
    output fwd_sel_e         sel
);

    logic hit_mem;
    logic hit_wb;

    always_comb begin
        hit_mem = en && use_src && mem_v && mem_wr && (mem_dst == src);
        hit_wb  = en && use_src && wb_v && wb_wr && (wb_dst == src);
        // the younger producer wins
        if (hit_mem) begin
            sel = FWD_MEM;
        end else if (hit_wb) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_RF;
        end
    end

endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             fwd_en,
    input  logic             mem_shared,
    input  logic             fetch_avail,
    input  logic             z_flag,
    input  logic             id_v,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_use_a,
    input  logic             id_use_b,
    input  logic             ex_v,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic             ex_ld,
    input  logic             ex_br,
    input  logic             ex_ne,
    input  logic             mem_v,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic             mem_ld,
    input  logic             mem_st,
    output act_e             act,
    output logic             stall,
    output logic             flush,
    output logic             fetch_go
);

    logic reads_ex;
    logic reads_mem;
    logic load_use;
    logic no_bypass;
    logic taken;
    logic port_busy;

    function automatic logic needs(input logic ua, input logic [REG_W-1:0] sa,
                                   input logic ub, input logic [REG_W-1:0] sb,
                                   input logic [REG_W-1:0] d);
        return (ua && (sa == d)) || (ub && (sb == d));
    endfunction

    // decision: pick one action per cycle, in priority order
    always_comb begin
        reads_ex  = id_v && needs(id_use_a, id_src_a, id_use_b, id_src_b, ex_dst);
        reads_mem = id_v && needs(id_use_a, id_src_a, id_use_b, id_src_b, mem_dst);
        load_use  = reads_ex && ex_v && ex_wr && ex_ld;
        no_bypass = !fwd_en && ((reads_ex && ex_v && ex_wr) || (reads_mem && mem_v && mem_wr));
        taken     = ex_v && ex_br && (z_flag != ex_ne);
        port_busy = mem_shared && mem_v && (mem_ld || mem_st);

        if (taken) begin
            act = ACT_SQUASH;
        end else if (load_use || no_bypass) begin
            act = ACT_DATA_STALL;
        end else if (port_busy) begin
            act = ACT_PORT_HOLD;
        end else begin
            act = ACT_ADVANCE;
        end
    end

    // outputs per action
    always_comb begin
        stall    = 1'b0;
        flush    = 1'b0;
        fetch_go = 1'b0;
        unique case (act)
            ACT_ADVANCE: begin
                fetch_go = fetch_avail;
            end
            ACT_PORT_HOLD: begin
                fetch_go = 1'b0;
            end
            ACT_DATA_STALL: begin
                stall = 1'b1;
            end
            ACT_SQUASH: begin
                flush    = 1'b1;
                fetch_go = fetch_avail && !port_busy;
            end
        endcase
    end

endmodule

// File: rtl/hz_track.sv
module hz_track
    import hz_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_e             act,
    input  logic             fetch_go,
    input  logic [REG_W-1:0] id_dst,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_wr,
    input  logic             id_use_a,
    input  logic             id_use_b,
    input  logic             id_ld,
    input  logic             id_st,
    input  logic             id_br,
    input  logic             id_ne,
    output logic             id_v,
    output logic             ex_v,
    output logic [REG_W-1:0] ex_dst,
    output logic [REG_W-1:0] ex_src_a,
    output logic [REG_W-1:0] ex_src_b,
    output logic             ex_wr,
    output logic             ex_use_a,
    output logic             ex_use_b,
    output logic             ex_ld,
    output logic             ex_st,
    output logic             ex_br,
    output logic             ex_ne,
    output logic             mem_v,
    output logic [REG_W-1:0] mem_dst,
    output logic             mem_wr,
    output logic             mem_ld,
    output logic             mem_st,
    output logic             wb_v,
    output logic [REG_W-1:0] wb_dst,
    output logic             wb_wr,
    output logic [CNT_W-1:0] cycle_count
);

    logic id_v_n;
    logic ex_take;

    // next-state selection from the chosen action
    always_comb begin
        id_v_n  = id_v;
        ex_take = 1'b0;
        unique case (act)
            ACT_ADVANCE, ACT_PORT_HOLD: begin
                ex_take = id_v;
                id_v_n  = fetch_go;
            end
            ACT_DATA_STALL: begin
                ex_take = 1'b0;
                id_v_n  = id_v;
            end
            ACT_SQUASH: begin
                ex_take = 1'b0;
                id_v_n  = 1'b0;
            end
        endcase
    end

    // stage register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_v        <= 1'b0;
            ex_v        <= 1'b0;
            ex_dst      <= '0;
            ex_src_a    <= '0;
            ex_src_b    <= '0;
            ex_wr       <= 1'b0;
            ex_use_a    <= 1'b0;
            ex_use_b    <= 1'b0;
            ex_ld       <= 1'b0;
            ex_st       <= 1'b0;
            ex_br       <= 1'b0;
            ex_ne       <= 1'b0;
            mem_v       <= 1'b0;
            mem_dst     <= '0;
            mem_wr      <= 1'b0;
            mem_ld      <= 1'b0;
            mem_st      <= 1'b0;
            wb_v        <= 1'b0;
            wb_dst      <= '0;
            wb_wr       <= 1'b0;
            cycle_count <= '0;
        end else begin
            id_v <= id_v_n;
            ex_v <= ex_take;
            if (ex_take) begin
                ex_dst   <= id_dst;
                ex_src_a <= id_src_a;
                ex_src_b <= id_src_b;
                ex_wr    <= id_wr;
                ex_use_a <= id_use_a;
                ex_use_b <= id_use_b;
                ex_ld    <= id_ld;
                ex_st    <= id_st;
                ex_br    <= id_br;
                ex_ne    <= id_ne;
            end
            mem_v       <= ex_v;
            mem_dst     <= ex_dst;
            mem_wr      <= ex_wr;
            mem_ld      <= ex_ld;
            mem_st      <= ex_st;
            wb_v        <= mem_v;
            wb_dst      <= mem_dst;
            wb_wr       <= mem_wr;
            cycle_count <= cycle_count + 1'b1;
        end
    end

    AST_SQUASH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_SQUASH) |=> (!id_v && !ex_v)); // R6

    AST_STALL_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_DATA_STALL) |=> (id_v && !ex_v)); // R3

    AST_WB_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_v |=> wb_v); // R12

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cycle_count == $past(cycle_count) + 1'b1)); // R10

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en,
    input  logic             mem_shared,
    input  logic             fetch_avail,
    input  logic             z_flag,
    input  logic [REG_W-1:0] id_dst,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_wr,
    input  logic             id_use_a,
    input  logic             id_use_b,
    input  logic             id_load,
    input  logic             id_store,
    input  logic             id_branch,
    input  logic             id_br_ne,
    output logic             fetch_go,
    output logic             stall,
    output logic             flush,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic [3:0]       stage_valid,
    output logic [CNT_W-1:0] cycle_count
);

    localparam int N_OPS = 2;

    act_e             act;
    logic             id_v;
    logic             ex_v, ex_wr, ex_use_a, ex_use_b, ex_ld, ex_st, ex_br, ex_ne;
    logic [REG_W-1:0] ex_dst, ex_src_a, ex_src_b;
    logic             mem_v, mem_wr, mem_ld, mem_st;
    logic [REG_W-1:0] mem_dst;
    logic             wb_v, wb_wr;
    logic [REG_W-1:0] wb_dst;

    logic [REG_W-1:0] op_src [N_OPS];
    logic             op_use [N_OPS];
    fwd_sel_e         op_sel [N_OPS];

    hz_track #(.REG_W(REG_W), .CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .fetch_go   (fetch_go),
        .id_dst     (id_dst),
        .id_src_a   (id_src_a),
        .id_src_b   (id_src_b),
        .id_wr      (id_wr),
        .id_use_a   (id_use_a),
        .id_use_b   (id_use_b),
        .id_ld      (id_load),
        .id_st      (id_store),
        .id_br      (id_branch),
        .id_ne      (id_br_ne),
        .id_v       (id_v),
        .ex_v       (ex_v),
        .ex_dst     (ex_dst),
        .ex_src_a   (ex_src_a),
        .ex_src_b   (ex_src_b),
        .ex_wr      (ex_wr),
        .ex_use_a   (ex_use_a),
        .ex_use_b   (ex_use_b),
        .ex_ld      (ex_ld),
        .ex_st      (ex_st),
        .ex_br      (ex_br),
        .ex_ne      (ex_ne),
        .mem_v      (mem_v),
        .mem_dst    (mem_dst),
        .mem_wr     (mem_wr),
        .mem_ld     (mem_ld),
        .mem_st     (mem_st),
        .wb_v       (wb_v),
        .wb_dst     (wb_dst),
        .wb_wr      (wb_wr),
        .cycle_count(cycle_count)
    );

    hz_detect #(.REG_W(REG_W)) u_detect (
        .fwd_en     (fwd_en),
        .mem_shared (mem_shared),
        .fetch_avail(fetch_avail),
        .z_flag     (z_flag),
        .id_v       (id_v),
        .id_src_a   (id_src_a),
        .id_src_b   (id_src_b),
        .id_use_a   (id_use_a),
        .id_use_b   (id_use_b),
        .ex_v       (ex_v),
        .ex_dst     (ex_dst),
        .ex_wr      (ex_wr),
        .ex_ld      (ex_ld),
        .ex_br      (ex_br),
        .ex_ne      (ex_ne),
        .mem_v      (mem_v),
        .mem_dst    (mem_dst),
        .mem_wr     (mem_wr),
        .mem_ld     (mem_ld),
        .mem_st     (mem_st),
        .act        (act),
        .stall      (stall),
        .flush      (flush),
        .fetch_go   (fetch_go)
    );

    assign op_src[0] = ex_src_a;
    assign op_src[1] = ex_src_b;
    assign op_use[0] = ex_use_a;
    assign op_use[1] = ex_use_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        hz_fwd_pick #(.REG_W(REG_W)) u_pick (
            .en     (fwd_en),
            .use_src(op_use[g] && ex_v),
            .src    (op_src[g]),
            .mem_v  (mem_v),
            .mem_wr (mem_wr),
            .mem_dst(mem_dst),
            .wb_v   (wb_v),
            .wb_wr  (wb_wr),
            .wb_dst (wb_dst),
            .sel    (op_sel[g])
        );
    end

    assign fwd_a       = op_sel[0];
    assign fwd_b       = op_sel[1];
    assign stage_valid = {wb_v, mem_v, ex_v, id_v};

    AST_PORT_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_shared && mem_v && (mem_ld || mem_st)) |-> !fetch_go); // R5

    AST_LOAD_NOT_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_v && mem_ld) |-> (fwd_a != FWD_MEM && fwd_b != FWD_MEM)); // R3

    AST_BYPASS_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |-> (fwd_a == FWD_RF && fwd_b == FWD_RF)); // R4

    AST_FLUSH_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (ex_v && ex_br)); // R6

endmodule

// File: tb/pipe_hazard_ctrl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_test;

    localparam int RW   = 4;
    localparam int CW   = 16;
    localparam int MAXP = 16;

    typedef struct packed {
        logic [3:0] d;
        logic [3:0] a;
        logic [3:0] b;
        logic       wr, ua, ub, ld, st, br, ne, z;
        logic [7:0] tgt;
    } ins_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, fwd_en, mem_shared, fetch_avail, z_flag;
    logic [RW-1:0] id_dst, id_src_a, id_src_b;
    logic          id_wr, id_use_a, id_use_b, id_load, id_store, id_branch, id_br_ne;
    logic          fetch_go, stall, flush;
    logic [1:0]    fwd_a, fwd_b;
    logic [3:0]    stage_valid;
    logic [CW-1:0] cycle_count;

    pipe_hazard_ctrl #(.REG_W(RW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .mem_shared(mem_shared),
        .fetch_avail(fetch_avail), .z_flag(z_flag),
        .id_dst(id_dst), .id_src_a(id_src_a), .id_src_b(id_src_b),
        .id_wr(id_wr), .id_use_a(id_use_a), .id_use_b(id_use_b),
        .id_load(id_load), .id_store(id_store), .id_branch(id_branch), .id_br_ne(id_br_ne),
        .fetch_go(fetch_go), .stall(stall), .flush(flush),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stage_valid(stage_valid), .cycle_count(cycle_count)
    );

    ins_t prog [MAXP];
    int   n_prog;
    int   vecs = 0;
    int   bad  = 0;
    bit   done = 0;

    localparam int K_ALU = 0, K_LD = 1, K_ST = 2, K_BEQ = 3, K_BNE = 4, K_CMP = 5;

    task automatic put(input int i, input int k, input int d, input int a, input int b,
                       input int t, input bit z);
        ins_t x;
        x = '0;
        x.d = d[3:0]; x.a = a[3:0]; x.b = b[3:0]; x.tgt = t[7:0]; x.z = z;
        case (k)
            K_ALU: begin x.wr = 1; x.ua = 1; x.ub = 1; end
            K_LD:  begin x.wr = 1; x.ld = 1; x.ua = 1; end
            K_ST:  begin x.st = 1; x.ua = 1; x.ub = 1; end
            K_BEQ: begin x.br = 1; end
            K_BNE: begin x.br = 1; x.ne = 1; end
            K_CMP: begin x.ua = 1; x.ub = 1; end
            default: ;
        endcase
        prog[i] = x;
        if (i + 1 > n_prog) n_prog = i + 1;
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        vecs++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit reads(input ins_t c, input logic [3:0] r);
        return (c.ua && c.a == r) || (c.ub && c.b == r);
    endfunction

    function automatic int fsel(input bit fe, input int e, input int m, input int w,
                                input bit use_src, input logic [3:0] s);
        if (!fe || e < 0 || !use_src) return 0;
        if (m >= 0 && prog[m].wr && prog[m].d == s) return 1;
        if (w >= 0 && prog[w].wr && prog[w].d == s) return 2;
        return 0;
    endfunction

    task automatic run(input string rt, input bit fe, input bit sh, output int last_ret);
        int idi, exi, memi, wbi, pc, cyc;
        ins_t ci, ce, cm;
        bit idv, exv, memv, wbv, lu, nf, hz, tk, port, e_fetch;
        fwd_en = fe; mem_shared = sh; fetch_avail = 0; z_flag = 0;
        id_dst = 0; id_src_a = 0; id_src_b = 0; id_wr = 0; id_use_a = 0; id_use_b = 0;
        id_load = 0; id_store = 0; id_branch = 0; id_br_ne = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk({rt, " R11 valid in reset"}, stage_valid, 0);
        chk({rt, " R11 count in reset"}, cycle_count, 0);
        chk({rt, " R11 stall/flush in reset"}, {stall, flush}, 0);
        chk({rt, " R11 bypass in reset"}, {fwd_a, fwd_b}, 0);
        rst_n = 1;
        idi = -1; exi = -1; memi = -1; wbi = -1; pc = 0; cyc = 0; last_ret = -1;
        for (int k = 0; k < 200; k++) begin
            idv = idi >= 0; exv = exi >= 0; memv = memi >= 0; wbv = wbi >= 0;
            ci = idv ? prog[idi] : '0;
            ce = exv ? prog[exi] : '0;
            cm = memv ? prog[memi] : '0;
            fetch_avail = pc < n_prog;
            id_dst = ci.d; id_src_a = ci.a; id_src_b = ci.b; id_wr = ci.wr;
            id_use_a = ci.ua; id_use_b = ci.ub; id_load = ci.ld; id_store = ci.st;
            id_branch = ci.br; id_br_ne = ci.ne;
            z_flag = ce.z;
            #1;
            lu = exv && ce.ld && ce.wr && idv && reads(ci, ce.d);
            nf = !fe && idv && ((exv && ce.wr && reads(ci, ce.d)) || (memv && cm.wr && reads(ci, cm.d)));
            hz = lu || nf;
            tk = exv && ce.br && (ce.z != ce.ne);
            port = sh && memv && (cm.ld || cm.st);
            e_fetch = (pc < n_prog) && !port && (tk || !hz);
            chk({rt, " R12 fetch_go"}, fetch_go, e_fetch);
            chk({rt, " R3 stall"}, stall, hz && !tk);
            chk({rt, " R6 flush"}, flush, tk);
            chk({rt, " R1 fwd_a"}, fwd_a, fsel(fe, exi, memi, wbi, ce.ua, ce.a));
            chk({rt, " R1 fwd_b"}, fwd_b, fsel(fe, exi, memi, wbi, ce.ub, ce.b));
            chk({rt, " R9 stage_valid"}, stage_valid, {wbv, memv, exv, idv});
            chk({rt, " R10 cycle_count"}, cycle_count, cyc);
            if (wbv && wbi == n_prog - 1) last_ret = cyc;
            wbi = memi;
            memi = exi;
            exi = (tk || hz) ? -1 : idi;
            idi = tk ? -1 : (hz ? idi : (e_fetch ? pc : -1));
            if (tk) pc = ce.tgt;
            else if (e_fetch) pc++;
            cyc++;
            @(negedge clk);
            if (idi < 0 && exi < 0 && memi < 0 && wbi < 0 && pc >= n_prog) break;
        end
    endtask

    initial begin
        int lr;
        rst_n = 0;

        // P1: load-use twice, bypassing on, split memory ports
        n_prog = 0;
        put(0, K_LD, 1, 0, 0, 0, 0);
        put(1, K_LD, 2, 0, 0, 0, 0);
        put(2, K_ALU, 3, 1, 2, 0, 0);
        put(3, K_ST, 0, 0, 3, 0, 0);
        put(4, K_LD, 4, 0, 0, 0, 0);
        put(5, K_ALU, 5, 1, 4, 0, 0);
        put(6, K_ST, 0, 0, 5, 0, 0);
        run("P1 R3", 1, 0, lr);
        chk("P1 R10 total cycles", lr + 1, 13);

        // P2: same work reordered
        n_prog = 0;
        put(0, K_LD, 1, 0, 0, 0, 0);
        put(1, K_LD, 2, 0, 0, 0, 0);
        put(2, K_LD, 4, 0, 0, 0, 0);
        put(3, K_ALU, 3, 1, 2, 0, 0);
        put(4, K_ST, 0, 0, 3, 0, 0);
        put(5, K_ALU, 5, 1, 4, 0, 0);
        put(6, K_ST, 0, 0, 5, 0, 0);
        run("P2 R10", 1, 0, lr);
        chk("P2 R10 total cycles", lr + 1, 11);

        // P3: bypass priority and register 0
        n_prog = 0;
        put(0, K_ALU, 2, 1, 3, 0, 0);
        put(1, K_ALU, 2, 2, 5, 0, 0);
        put(2, K_ALU, 4, 2, 2, 0, 0);
        put(3, K_ALU, 0, 6, 7, 0, 0);
        put(4, K_ALU, 9, 8, 8, 0, 0);
        put(5, K_ALU, 10, 0, 0, 0, 0);
        run("P3 R2", 1, 0, lr);

        // P4: same program with bypassing off
        run("P4 R4", 0, 0, lr);
        chk("P4 R4 stalled run longer", (lr + 1 > 10) ? 1 : 0, 1);

        // P5: shared memory port
        n_prog = 0;
        put(0, K_LD, 1, 0, 0, 0, 0);
        put(1, K_LD, 2, 0, 0, 0, 0);
        put(2, K_ALU, 3, 1, 2, 0, 0);
        put(3, K_ST, 0, 0, 3, 0, 0);
        put(4, K_ALU, 6, 7, 8, 0, 0);
        run("P5 R5", 1, 1, lr);

        // P6: taken then not-taken branch, squashed writer must not bypass
        n_prog = 0;
        put(0, K_CMP, 0, 2, 0, 0, 0);
        put(1, K_BEQ, 0, 0, 0, 4, 1);
        put(2, K_ALU, 7, 1, 1, 0, 0);
        put(3, K_ALU, 8, 1, 1, 0, 0);
        put(4, K_ALU, 9, 7, 7, 0, 0);
        put(5, K_BNE, 0, 0, 0, 0, 1);
        put(6, K_ALU, 1, 9, 9, 0, 0);
        put(7, K_ALU, 11, 1, 9, 0, 0);
        run("P6 R7", 1, 0, lr);

        // P7: flush meets a data stall and a port conflict together
        n_prog = 0;
        put(0, K_LD, 3, 0, 0, 0, 0);
        put(1, K_BEQ, 0, 0, 0, 4, 1);
        put(2, K_ALU, 5, 3, 3, 0, 0);
        put(3, K_ALU, 6, 3, 3, 0, 0);
        put(4, K_ALU, 7, 3, 3, 0, 0);
        run("P7 R8", 0, 1, lr);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

endmodule